// File: doc/BRIEF.md
# Interrupt Vector Dispatch Controller

This block picks the address that a small microcontroller core with a 10-bit program counter fetches from next. It does so when reset is released and when an interrupt is accepted. It serves three request sources: an active-low external pin, a timer overflow pulse and a converter-done pulse. Each source has a pending latch, so a request is never lost while it waits. The latch is set by the source event and cleared only when that source is dispatched.

A pending request is dispatched only when all of the following hold: its own enable is set, the global interrupt enable is set, and the call stack reports a free slot. A dispatch has three effects in one cycle. It pulses the vector-load strobe with the source's fixed vector, raises a push request so the stack saves the return address, and clears the global enable. Software sets or clears the global enable again through a write strobe. The current value of the global enable is visible as an output.

Top module: `ivd_top`

## Requirements
- R1: While `rst_n` is low, `vec_load`, `push_req` and `gie_o` are 0 and all pending latches are cleared. After the first rising edge with `rst_n` high, `vec_load` is 1 for exactly one cycle with `vec_addr` = 0x000 and `push_req` = 0.
- R2: A high-to-low transition on `ext_pin_n` requests vector 0x004. The pin passes through two synchroniser flops. The first rising edge that samples the pin low is edge k. If the request is eligible, `vec_load` is high in the cycle after edge k+3.
- R3: A one-cycle high pulse on `tmr_ovf` requests vector 0x008. If that pulse is sampled at edge j and the request is eligible, `vec_load` is high in the cycle after edge j+1.
- R4: A one-cycle high pulse on `adc_done` requests vector 0x00C, with the same timing as R3.
- R5: When several requests are eligible in the same cycle, the external pin is served first, then the timer, then the converter. One source is served per dispatch.
- R6: A pending request whose source enable is 0 is held. It is dispatched once the enable becomes 1.
- R7: No dispatch happens while `stack_full` is 1. A pending request is held and dispatched after `stack_full` returns to 0.
- R8: No dispatch happens while the global enable is 0. Pending requests are held until it is set.
- R9: A dispatch raises `push_req` in the same cycle as `vec_load` and clears the global enable (`gie_o` = 0 in that cycle). It also clears only the served source's latch, so re-enabling does not dispatch the same request twice.
- R10: A low-to-high transition on `ext_pin_n` requests nothing.
- R11: When `gie_wr` is 1 at a rising edge, `gie_o` takes the value of `gie_wdata` after that edge. Otherwise `gie_o` holds its value unless a dispatch clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 1 | Raw external request pin; a falling edge requests |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_done | input | 1 | Converter-done pulse |
| ext_en | input | 1 | External source enable |
| tmr_en | input | 1 | Timer source enable |
| adc_en | input | 1 | Converter source enable |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | Value written to the global enable |
| stack_full | input | 1 | Call stack has no free slot |
| vec_load | output | 1 | Load `vec_addr` into the program counter |
| vec_addr | output | 10 | Vector address |
| push_req | output | 1 | Push the return address onto the stack |
| gie_o | output | 1 | Current global enable |

## Verification
The bench tries each source on its own first. This separates the three vector values and shows the different latencies of the synchronised pin and the direct pulses. It then holds all three requests pending behind a cleared global enable and releases them one at a time. The order of the vectors that come out exposes the priority and shows whether a served latch is cleared while the others stay set. Next, a request is blocked in turn by its source enable, by a full stack and by a rising pin edge. These cases show whether a blocked request is held or dropped, and whether an edge that should be ignored creates a spurious dispatch.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
    localparam int ADDR_W = 10;
    localparam int NSRC   = 3;
    localparam int STRIDE = 4;

    typedef struct packed {
        logic              boot;
        logic              gie;
        logic              vload;
        logic              push;
        logic [ADDR_W-1:0] vaddr;
        logic [NSRC-1:0]   pend;
    } disp_st_t;
endpackage

// File: rtl/ivd_sync.sv
module ivd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

    // R10
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/ivd_arbiter.sv
module ivd_arbiter #(
    parameter int NSRC   = 3,
    parameter int ADDR_W = 10,
    parameter int STRIDE = 4
) (
    input  logic [NSRC-1:0]   req,
    output logic [NSRC-1:0]   grant,
    output logic              any,
    output logic [ADDR_W-1:0] vec
);
    always_comb begin
        grant = '0;
        vec   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vec      = ADDR_W'((i + 1) * STRIDE);
            end
        end
        any = |req;
    end

    // R5
    always_comb begin
        grant_onehot_chk: assert ($onehot0(grant));
    end
endmodule

// File: rtl/ivd_top.sv
module ivd_top
    import ivd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin_n,
    input  logic              tmr_ovf,
    input  logic              adc_done,
    input  logic              ext_en,
    input  logic              tmr_en,
    input  logic              adc_en,
    input  logic              gie_wr,
    input  logic              gie_wdata,
    input  logic              stack_full,
    output logic              vec_load,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              push_req,
    output logic              gie_o
);
    disp_st_t st_d, st_q;

    logic              ext_fall;
    logic [NSRC-1:0]   raw_req;
    logic [NSRC-1:0]   src_en;
    logic [NSRC-1:0]   elig;
    logic [NSRC-1:0]   grant;
    logic              any;
    logic [ADDR_W-1:0] vec;

    ivd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_pin_n),
        .fall  (ext_fall)
    );

    assign raw_req = {adc_done, tmr_ovf, ext_fall};
    assign src_en  = {adc_en, tmr_en, ext_en};
    assign elig    = st_q.pend & src_en
                   & {NSRC{st_q.gie & ~stack_full & ~st_q.boot}};

    ivd_arbiter #(.NSRC(NSRC), .ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_arb (
        .req   (elig),
        .grant (grant),
        .any   (any),
        .vec   (vec)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vload = 1'b0;
        st_d.push  = 1'b0;
        st_d.pend  = (st_q.pend & ~grant) | raw_req;
        if (gie_wr) st_d.gie = gie_wdata;
        if (st_q.boot) begin
            st_d.boot  = 1'b0;
            st_d.vload = 1'b1;
            st_d.vaddr = '0;
        end else if (any) begin
            st_d.vload = 1'b1;
            st_d.push  = 1'b1;
            st_d.vaddr = vec;
            st_d.gie   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.boot <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_load = st_q.vload;
    assign vec_addr = st_q.vaddr;
    assign push_req = st_q.push;
    assign gie_o    = st_q.gie;

    // R9
    push_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> vec_load);
    // R9
    gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> !gie_o);
    // R7
    stack_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> !$past(stack_full));
    // R8
    gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> $past(gie_o));
    // R2
    vec_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> (vec_addr != '0));
endmodule

// File: tb/sim_ivd_top.sv
module sim_ivd_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       ext_pin_n = 1, tmr_ovf = 0, adc_done = 0;
    logic       ext_en = 1, tmr_en = 1, adc_en = 1;
    logic       gie_wr = 0, gie_wdata = 0, stack_full = 0;
    logic       vec_load, push_req, gie_o;
    logic [9:0] vec_addr;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int exp_addr[$];
    bit exp_push[$];
    string exp_tag[$];

    always #10 clk = ~clk;

    ivd_top u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .tmr_ovf(tmr_ovf),
        .adc_done(adc_done), .ext_en(ext_en), .tmr_en(tmr_en), .adc_en(adc_en),
        .gie_wr(gie_wr), .gie_wdata(gie_wdata), .stack_full(stack_full),
        .vec_load(vec_load), .vec_addr(vec_addr), .push_req(push_req), .gie_o(gie_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic expect_vec(input int a, input bit p, input string tag);
        exp_addr.push_back(a);
        exp_push.push_back(p);
        exp_tag.push_back(tag);
    endtask

    // Monitor: pops the expected dispatch and compares
    always @(negedge clk) begin
        if (rst_n && vec_load) begin
            if (exp_addr.size() == 0) begin
                check(0, "R9/R10 unexpected vec_load", int'(vec_addr), 0);
            end else begin
                int a; bit p; string t;
                a = exp_addr.pop_front();
                p = exp_push.pop_front();
                t = exp_tag.pop_front();
                check(vec_addr == a[9:0], t, int'(vec_addr), a);
                check(push_req == p, {t, " push"}, int'(push_req), int'(p));
                if (p) check(gie_o == 0, "R9 gie cleared", int'(gie_o), 0);
            end
        end
    end

    task automatic set_gie(input bit v);
        @(negedge clk); gie_wr = 1; gie_wdata = v;
        @(negedge clk); gie_wr = 0;
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr_ovf = 1;
        @(negedge clk); tmr_ovf = 0;
    endtask

    task automatic pulse_adc();
        @(negedge clk); adc_done = 1;
        @(negedge clk); adc_done = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic no_load(input int n, input string req);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (vec_load) seen = 1;
        end
        check(!seen, req, int'(seen), 0);
    endtask

    task automatic drain(input string req);
        check(exp_addr.size() == 0, req, exp_addr.size(), 0);
    endtask

    initial begin
        // R1 reset state
        idle(3);
        check(vec_load == 0, "R1 vec_load in reset", int'(vec_load), 0);
        check(push_req == 0, "R1 push in reset", int'(push_req), 0);
        check(gie_o == 0, "R1 gie in reset", int'(gie_o), 0);
        expect_vec(0, 0, "R1 boot vector");
        rst_n = 1;
        idle(4);
        drain("R1 boot seen");

        // R11 global enable write
        set_gie(1);
        check(gie_o == 1, "R11 gie set", int'(gie_o), 1);

        // R3 timer
        expect_vec(8, 1, "R3 timer vector");
        pulse_tmr();
        idle(3);
        drain("R3 dispatched");

        // R4 converter
        set_gie(1);
        expect_vec(12, 1, "R4 adc vector");
        pulse_adc();
        idle(3);
        drain("R4 dispatched");

        // R2 external pin with latency
        set_gie(1);
        expect_vec(4, 1, "R2 ext vector");
        @(negedge clk); ext_pin_n = 0;
        idle(3);
        check(vec_load == 0, "R2 latency early", int'(vec_load), 0);
        @(negedge clk);
        check(vec_load == 1, "R2 latency", int'(vec_load), 1);
        idle(2);
        drain("R2 dispatched");

        // R10 rising edge requests nothing; R9 no double dispatch
        set_gie(1);
        @(negedge clk); ext_pin_n = 1;
        no_load(8, "R10 rising edge / R9 no repeat");

        // R5 priority with everything pending, R8 hold while gie low
        set_gie(0);
        @(negedge clk); ext_pin_n = 0; tmr_ovf = 1; adc_done = 1;
        @(negedge clk); tmr_ovf = 0; adc_done = 0;
        no_load(6, "R8 held while gie low");
        expect_vec(4, 1, "R5 first ext");
        set_gie(1);
        idle(2);
        expect_vec(8, 1, "R5 second timer");
        set_gie(1);
        idle(2);
        expect_vec(12, 1, "R5 third adc");
        set_gie(1);
        idle(2);
        drain("R5 order complete");
        @(negedge clk); ext_pin_n = 1;
        set_gie(1);
        no_load(6, "R9 latches cleared");

        // R6 source enable holds request
        @(negedge clk); tmr_en = 0;
        pulse_tmr();
        no_load(5, "R6 held while disabled");
        expect_vec(8, 1, "R6 taken when enabled");
        @(negedge clk); tmr_en = 1;
        idle(3);
        drain("R6 dispatched");

        // R7 stack full holds request
        set_gie(1);
        @(negedge clk); stack_full = 1;
        pulse_adc();
        no_load(5, "R7 held while stack full");
        expect_vec(12, 1, "R7 taken after room");
        @(negedge clk); stack_full = 0;
        idle(3);
        drain("R7 dispatched");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule